// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block collects the interrupt sources of a FIFO-based UART and picks the single most urgent one. It reports that one as a 4-bit identification code. It also drives an interrupt request line and a character time-out flag. There are three sources that latch, plus one level source:

- A receive line-status source, which latches on any receive error.
- A receive-data level source, which follows the receive FIFO fill against a selectable trigger threshold.
- A receive idle time-out, which fires when characters wait in the receive FIFO and nothing moves for about four character times.
- A transmit-empty source, which fires when the transmit FIFO drains.

Each latched source has its own clear rule. The line-status source clears on a status read. The time-out clears on receive FIFO activity. The transmit-empty source clears on a transmit write, or on an identification read while it is the reported source.

The idle timer counts 16x baud ticks, so the time-out scales with the baud rate. Software uses the time-out to collect the tail of a message that does not fill a whole trigger block. Every source can be disabled through an enable vector. A disabled source never takes part in selection.

Top module: `uart_iid`

## Requirements
- R1: The identification code takes only these values: 0001 when nothing is pending, 0110 for line status, 0100 for receive data, 1100 for time-out, and 0010 for transmit empty. Bit 0 is 0 exactly when an enabled source is pending. irq_o is the inverse of bit 0.
- R2: Priority is fixed. Line status comes first. Receive data and time-out share the second level. Transmit empty is last.
- R3: When receive data and time-out are both pending, the code reports receive data (0100).
- R4: The line-status source sets on the clock edge after any bit of rx_err_i is high. The bits are: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break. It clears on the edge after lsr_rd_i, unless a new error arrives in that same cycle, in which case it stays set.
- R5: Receive data is pending, without a register delay, whenever rx_cnt_i is at least the threshold picked by trig_sel_i. The thresholds are 0→1, 1→4, 2→8 and 3→14. It drops as soon as the count falls below the threshold.
- R6: The time-out flag sets once TMO_TICKS baud ticks (640 by default) have elapsed since the last receive FIFO read or write, provided the FIFO count is nonzero. It is not set after TMO_TICKS−1 ticks. It never sets while the count is zero.
- R7: A receive FIFO read or write clears the time-out flag on the next edge and restarts the idle count. cto_o shows the flag whether or not the time-out source is enabled.
- R8: Transmit empty sets on the edge after tx_empty_i rises, once armed. It clears on the edge after thr_wr_i.
- R9: An identification read clears transmit empty only when 0010 is the code shown in that cycle. A read while a higher code is shown leaves it pending.
- R10: After reset, transmit empty stays suppressed until the first transmit write.
- R11: Enable bits are: bit 0 line status, bit 1 receive data, bit 2 time-out, bit 3 transmit empty. A cleared bit removes that source from selection.
- R12: During and after reset, the code is 0001, and irq_o and cto_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_err_i | input | 4 | Receive error strobes: overrun, parity, framing, break |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| rx_rd_i | input | 1 | Receive FIFO read strobe |
| rx_wr_i | input | 1 | Receive FIFO write strobe |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| trig_sel_i | input | 2 | Receive trigger threshold select |
| baud_tick_i | input | 1 | 16x baud tick |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| irq_en_i | input | 4 | Per-source enables |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |
| cto_o | output | 1 | Character time-out flag |

## Verification
The bench probes the time-out at exactly TMO_TICKS−1 and TMO_TICKS ticks after the last activity. An off-by-one timer would fire one tick early or late. It also re-probes the time-out after a read restarts the timer; a timer that is not restarted would fire at once. A line-status error is raised in the same cycle as a status read; a design that lets the clear win would drop a fresh error. An identification read is issued while line status hides a pending transmit-empty source. A design that clears on any read would lose the transmit-empty interrupt. The bench also checks every threshold on both sides of its boundary, and checks transmit-empty suppression before the first write.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_LS   = 4'b0110,
        IID_RDA  = 4'b0100,
        IID_CTO  = 4'b1100,
        IID_THRE = 4'b0010
    } iid_e;

    localparam int N_SRC    = 4;
    localparam int SRC_LS   = 0;
    localparam int SRC_RDA  = 1;
    localparam int SRC_CTO  = 2;
    localparam int SRC_THRE = 3;

    localparam int N_ERR = 4;

endpackage

// File: rtl/uart_iid_tmo.sv
module uart_iid_tmo #(
    parameter int CNT_W     = 5,
    parameter int TMO_TICKS = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             rx_rd,
    input  logic             rx_wr,
    input  logic             tick,
    output logic             cto
);
    localparam int TW = (TMO_TICKS > 2) ? $clog2(TMO_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TMO_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          cto;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    logic activity;
    logic fifo_empty;

    always_comb begin
        activity   = rx_rd | rx_wr;
        fifo_empty = (rx_cnt == '0);
        st_d       = st_q;
        if (activity || fifo_empty) begin
            st_d.tmr = '0;
            st_d.cto = 1'b0;
        end else if (tick && !st_q.cto) begin
            if (st_q.tmr == LAST) begin
                st_d.tmr = '0;
                st_d.cto = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cto = st_q.cto;

    // R7
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd || rx_wr) |=> !cto);

    // R6
    tmo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |=> !cto);

    // R6
    tmo_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cto ##1 cto |-> $past(tick));

    // R6
    tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= LAST);

endmodule

// File: rtl/uart_iid_src.sv
module uart_iid_src
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] rx_err,
    input  logic             lsr_rd,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             thre_shown,
    output logic             ls,
    output logic             thre
);
    typedef struct packed {
        logic ls;
        logic thre;
        logic armed;
        logic empty_prev;
    } src_st_t;

    src_st_t st_d, st_q;

    logic any_err;
    logic empty_rise;

    always_comb begin
        any_err    = |rx_err;
        empty_rise = tx_empty & ~st_q.empty_prev;
        st_d       = st_q;

        st_d.empty_prev = tx_empty;
        st_d.armed      = st_q.armed | thr_wr;

        if (any_err) begin
            st_d.ls = 1'b1;
        end else if (lsr_rd) begin
            st_d.ls = 1'b0;
        end

        if (thr_wr) begin
            st_d.thre = 1'b0;
        end else if (st_q.armed && empty_rise) begin
            st_d.thre = 1'b1;
        end else if (iir_rd && thre_shown) begin
            st_d.thre = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ls: 1'b0, thre: 1'b0, armed: 1'b0, empty_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ls   = st_q.ls;
    assign thre = st_q.thre;

    // R4
    ls_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_err) |=> ls);

    // R4
    ls_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(|rx_err)) |=> !ls);

    // R10
    thre_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> !thre);

    // R8
    thre_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre);

    // R9
    thre_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thre && iir_rd && !thre_shown && !thr_wr) |=> thre);

endmodule

// File: rtl/uart_iid_arb.sv
module uart_iid_arb
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [1:0]       trig_sel,
    input  logic             ls,
    input  logic             cto,
    input  logic             thre,
    input  logic [N_SRC-1:0] en,
    output logic [3:0]       iid
);
    localparam logic [CNT_W-1:0] LVL0 = CNT_W'(TRIG0);
    localparam logic [CNT_W-1:0] LVL1 = CNT_W'(TRIG1);
    localparam logic [CNT_W-1:0] LVL2 = CNT_W'(TRIG2);
    localparam logic [CNT_W-1:0] LVL3 = CNT_W'(TRIG3);

    logic [CNT_W-1:0] level;
    logic             rda_raw;
    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] act;
    iid_e             code;

    always_comb begin
        unique case (trig_sel)
            2'd0:    level = LVL0;
            2'd1:    level = LVL1;
            2'd2:    level = LVL2;
            default: level = LVL3;
        endcase
        rda_raw = (rx_cnt >= level);
    end

    always_comb begin
        raw           = '0;
        raw[SRC_LS]   = ls;
        raw[SRC_RDA]  = rda_raw;
        raw[SRC_CTO]  = cto;
        raw[SRC_THRE] = thre;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign act[g] = raw[g] & en[g];
    end

    always_comb begin
        if (act[SRC_LS]) begin
            code = IID_LS;
        end else if (act[SRC_RDA]) begin
            code = IID_RDA;
        end else if (act[SRC_CTO]) begin
            code = IID_CTO;
        end else if (act[SRC_THRE]) begin
            code = IID_THRE;
        end else begin
            code = IID_NONE;
        end
    end

    assign iid = code;

    // R1
    iid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == 4'b0001) || (iid == 4'b0110) || (iid == 4'b0100) ||
        (iid == 4'b1100) || (iid == 4'b0010));

    // R1
    iid_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iid[0] == !(ls && en[0] || cto && en[2] || thre && en[3] || rda_raw && en[1]));

    // R2
    ls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls && en[0]) |-> (iid == 4'b0110));

    // R11
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (iid == 4'b0001));

endmodule

// File: rtl/uart_iid.sv
module uart_iid
    import uart_iid_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int TMO_TICKS = 640,
    parameter int TRIG0     = 1,
    parameter int TRIG1     = 4,
    parameter int TRIG2     = 8,
    parameter int TRIG3     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       rx_err_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             rx_rd_i,
    input  logic             rx_wr_i,
    input  logic             tx_empty_i,
    input  logic             thr_wr_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             baud_tick_i,
    input  logic             lsr_rd_i,
    input  logic             iir_rd_i,
    input  logic [3:0]       irq_en_i,
    output logic [3:0]       iid_o,
    output logic             irq_o,
    output logic             cto_o
);
    logic       cto_flag;
    logic       ls_flag;
    logic       thre_flag;
    logic [3:0] iid;
    logic       thre_shown;

    uart_iid_tmo #(
        .CNT_W     (CNT_W),
        .TMO_TICKS (TMO_TICKS)
    ) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_cnt (rx_cnt_i),
        .rx_rd  (rx_rd_i),
        .rx_wr  (rx_wr_i),
        .tick   (baud_tick_i),
        .cto    (cto_flag)
    );

    assign thre_shown = (iid == IID_THRE);

    uart_iid_src u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_err     (rx_err_i),
        .lsr_rd     (lsr_rd_i),
        .tx_empty   (tx_empty_i),
        .thr_wr     (thr_wr_i),
        .iir_rd     (iir_rd_i),
        .thre_shown (thre_shown),
        .ls         (ls_flag),
        .thre       (thre_flag)
    );

    uart_iid_arb #(
        .CNT_W (CNT_W),
        .TRIG0 (TRIG0),
        .TRIG1 (TRIG1),
        .TRIG2 (TRIG2),
        .TRIG3 (TRIG3)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_cnt   (rx_cnt_i),
        .trig_sel (trig_sel_i),
        .ls       (ls_flag),
        .cto      (cto_flag),
        .thre     (thre_flag),
        .en       (irq_en_i),
        .iid      (iid)
    );

    assign iid_o = iid;
    assign irq_o = ~iid[0];
    assign cto_o = cto_flag;

    // R12
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (iid_o == 4'b0001) && !irq_o && !cto_o);

endmodule

// File: tb/uart_iid_tb.sv
module uart_iid_tb;

    localparam int CNT_W = 5;
    localparam int TMO   = 640;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       rx_err = '0;
    logic [CNT_W-1:0] rx_cnt = '0;
    logic             rx_rd = 1'b0;
    logic             rx_wr = 1'b0;
    logic             tx_empty = 1'b1;
    logic             thr_wr = 1'b0;
    logic [1:0]       trig_sel = '0;
    logic             tick = 1'b0;
    logic             lsr_rd = 1'b0;
    logic             iir_rd = 1'b0;
    logic [3:0]       en = 4'hF;
    logic [3:0]       iid;
    logic             irq;
    logic             cto;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_iid #(.CNT_W(CNT_W), .TMO_TICKS(TMO)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_err_i    (rx_err),
        .rx_cnt_i    (rx_cnt),
        .rx_rd_i     (rx_rd),
        .rx_wr_i     (rx_wr),
        .tx_empty_i  (tx_empty),
        .thr_wr_i    (thr_wr),
        .trig_sel_i  (trig_sel),
        .baud_tick_i (tick),
        .lsr_rd_i    (lsr_rd),
        .iir_rd_i    (iir_rd),
        .irq_en_i    (en),
        .iid_o       (iid),
        .irq_o       (irq),
        .cto_o       (cto)
    );

    typedef struct packed {
        logic [1:0]       sel;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       en;
        logic [3:0]       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 5'd0,  4'hF, 4'b0001},
        '{2'd0, 5'd1,  4'hF, 4'b0100},
        '{2'd1, 5'd3,  4'hF, 4'b0001},
        '{2'd1, 5'd4,  4'hF, 4'b0100},
        '{2'd2, 5'd7,  4'hF, 4'b0001},
        '{2'd2, 5'd8,  4'hF, 4'b0100},
        '{2'd3, 5'd13, 4'hF, 4'b0001},
        '{2'd3, 5'd14, 4'hF, 4'b0100},
        '{2'd3, 5'd20, 4'hF, 4'b0100},
        '{2'd0, 5'd5,  4'hD, 4'b0001},
        '{2'd0, 5'd5,  4'h2, 4'b0100}
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_id(input string req, input logic [3:0] exp);
        chk(req, iid, exp);
        chk({req, " irq"}, {3'b0, irq}, {3'b0, ~exp[0]});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        steps(2);
        chk_id("R12", 4'b0001);
        chk("R12 cto", {3'b0, cto}, 4'b0);
        rst_n = 1'b1;
        step();
        chk_id("R12", 4'b0001);

        // R5 / R11 table of thresholds and masks (no ticks)
        for (int k = 0; k < NV; k++) begin
            trig_sel = TBL[k].sel;
            rx_cnt   = TBL[k].cnt;
            en       = TBL[k].en;
            #1;
            chk_id($sformatf("R5/R11 vec%0d", k), TBL[k].exp);
        end
        en = 4'hF;
        rx_cnt = '0;
        trig_sel = 2'd0;
        step();

        // R10 no transmit-empty before first write
        tx_empty = 1'b0; step();
        tx_empty = 1'b1; step();
        chk_id("R10", 4'b0001);

        // R8 arm by write, then rising empty sets
        thr_wr = 1'b1; tx_empty = 1'b0; step();
        thr_wr = 1'b0; step();
        chk_id("R8 after write", 4'b0001);
        tx_empty = 1'b1; step();
        chk_id("R8 set", 4'b0010);

        // R9 identification read clears when shown
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk_id("R9 read clear", 4'b0001);

        // R8 clear by write
        tx_empty = 1'b0; step();
        tx_empty = 1'b1; step();
        chk_id("R8 set again", 4'b0010);
        thr_wr = 1'b1; tx_empty = 1'b0; step(); thr_wr = 1'b0;
        chk_id("R8 write clear", 4'b0001);

        // R2 / R4 / R9 interplay
        tx_empty = 1'b1; step();
        chk_id("R8 pending", 4'b0010);
        rx_err = 4'b0010; step(); rx_err = '0;
        chk_id("R4 parity set R2", 4'b0110);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk_id("R9 hidden read", 4'b0110);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk_id("R4 clear R9 kept", 4'b0010);
        rx_cnt = 5'd1; #1;
        chk_id("R2 data over empty", 4'b0100);
        rx_err = 4'b1000; step(); rx_err = '0;
        chk_id("R2 break over data", 4'b0110);
        rx_err = 4'b0001; lsr_rd = 1'b1; step(); rx_err = '0; lsr_rd = 1'b0;
        chk_id("R4 set wins", 4'b0110);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk_id("R4 clear", 4'b0100);
        rx_cnt = '0; #1;
        chk_id("R5 drop", 4'b0010);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk_id("R9 clear", 4'b0001);

        // R6 time-out window
        trig_sel = 2'd3; rx_cnt = 5'd1; tick = 1'b1;
        rx_wr = 1'b1; step(); rx_wr = 1'b0;
        steps(TMO - 1);
        chk("R6 early", {3'b0, cto}, 4'b0);
        chk_id("R6 early", 4'b0001);
        step();
        chk("R6 fire", {3'b0, cto}, 4'b1);
        chk_id("R6 fire", 4'b1100);

        // R3 data ahead of time-out
        rx_cnt = 5'd14; #1;
        chk_id("R3", 4'b0100);
        rx_cnt = 5'd1; #1;

        // R7 flag visible while masked, R11
        en = 4'b1011; #1;
        chk_id("R11 masked cto", 4'b0001);
        chk("R7 flag masked", {3'b0, cto}, 4'b1);
        en = 4'hF;

        // R7 read clears and restarts
        rx_rd = 1'b1; step(); rx_rd = 1'b0;
        chk("R7 clear", {3'b0, cto}, 4'b0);
        steps(TMO - 1);
        chk("R7 restart early", {3'b0, cto}, 4'b0);
        step();
        chk("R7 restart fire", {3'b0, cto}, 4'b1);

        // R6 empty FIFO never times out
        rx_cnt = '0; rx_rd = 1'b1; step(); rx_rd = 1'b0;
        steps(TMO + 60);
        chk("R6 empty", {3'b0, cto}, 4'b0);
        chk_id("R6 empty", 4'b0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule